// File: doc/BRIEF.md
# Multi-Domain Level Request Merger

This block collects level-sensitive request signals from several independent source clock domains and produces one merged request level in a destination clock domain. Each requester has its own clock and its own active-low reset. A requester is set up as one of two kinds when the block is built. A raw-bit requester supplies its request directly. A decode requester supplies a state vector, and it is requesting while that vector equals a code chosen by a parameter.

Every requester first passes through a two-state machine clocked by its own source clock. The machine's state register is the only thing that feeds that requester's synchronizer. Each registered request then crosses into the destination domain through its own chain of destination-clocked flops. The merge is an OR that is formed only from the final stages of these chains. Because of this, no synchronizer input ever sees combinational logic or a mix of signals from different clocks. Downstream logic must read the merged output as a level and must not count its rising edges.

The source state machine has two states. In REQ_IDLE the request is low. In REQ_HELD the request is high. The machine moves from REQ_IDLE to REQ_HELD ("capture") at a source edge where the request condition is true. It moves from REQ_HELD back to REQ_IDLE ("release") at a source edge where the condition is false. Otherwise it stays in its current state.

Top module: `lvl_req_merger`

## Requirements
- R1: Each requester's state machine changes state only on a rising edge of its own source clock. It enters REQ_HELD ("capture") when the condition is true at that edge and returns to REQ_IDLE ("release") when the condition is false. A condition that is true only between two source edges has no effect on the output.
- R2: For a requester whose bit in DECODE_SEL is 1, the condition is true exactly when its STATE_W-bit slice of `src_state` (bits i*STATE_W upward) equals its slice of DECODE_CODE. The raw bit of that requester is ignored. For the other requesters the condition is the raw bit, and their state slice is ignored.
- R3: Each registered request crosses through its own chain of SYNC_DEPTH destination flops (SYNC_DEPTH at least 2). A change of a registered request reaches the output within SYNC_DEPTH+1 destination cycles.
- R4: `req_out` is 1 exactly when at least one requester's final synchronizer stage is 1.
- R5: A low source reset clears that requester's state to REQ_IDLE asynchronously and holds it there. A low `dst_rst_n` clears every synchronizer chain. `req_out` is 0 during reset and on the first destination edge after reset is released.
- R6: `req_out` is never 1 unless some requester's condition was true within one source period plus SYNC_DEPTH+2 destination periods before that moment.
- R7: A request that is held for at least SYNC_DEPTH+2 destination cycles after its source edge is seen as `req_out` = 1.
- R8: A handoff in which a new request rises and stays high for at least SYNC_DEPTH+2 destination cycles before the old request falls leaves `req_out` at 1 for the whole handoff.
- R9: When built with SYNC_DEPTH=3, the block produces exactly the output of a SYNC_DEPTH=2 build delayed by one destination cycle, provided both see the same inputs and clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | N_REQ | One clock per requester |
| src_rst_n | input | N_REQ | Asynchronous active-low reset per requester |
| src_req | input | N_REQ | Raw request bits (used by raw-bit requesters) |
| src_state | input | N_REQ*STATE_W | State vectors (used by decode requesters) |
| dst_clk | input | 1 | Destination clock |
| dst_rst_n | input | 1 | Asynchronous active-low destination reset |
| req_out | output | 1 | Merged request level |

## Verification
A change on a requester is due at the output after at most one source period for the source register plus SYNC_DEPTH+1 destination cycles for the crossing. The bench therefore waits eight destination cycles after each stimulus before it compares the output, and it samples on falling destination edges. The delay between the depth-2 and depth-3 builds is exact, so the bench compares it edge by edge against the previous sample of the depth-2 output. The no-phantom rule is monitored on every cycle with a window of two source periods plus SYNC_DEPTH+2 destination periods. The glitch case places a matching state between two source edges and expects a silent output for the next fifteen cycles.

// File: rtl/lrm_pkg.sv
`timescale 1ns/1ps
package lrm_pkg;
    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_HELD = 1'b1
    } req_state_e;

    function automatic int unsigned cnt_width(input int unsigned depth);
        return $clog2(depth + 1) + 1;
    endfunction
endpackage

// File: rtl/lrm_src_stage.sv
`timescale 1ns/1ps
module lrm_src_stage
    import lrm_pkg::*;
#(
    parameter int unsigned          STATE_W    = 3,
    parameter bit                   USE_DECODE = 1'b0,
    parameter logic [STATE_W-1:0]   MATCH_CODE = '0
) (
    input  logic               src_clk,
    input  logic               src_rst_n,
    input  logic               req_raw,
    input  logic [STATE_W-1:0] req_state,
    output logic               req_q
);
    req_state_e st_q, st_d;
    logic       cond;

    always_comb cond = USE_DECODE ? (req_state == MATCH_CODE) : req_raw;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            REQ_IDLE: if (cond)  st_d = REQ_HELD;   // capture
            REQ_HELD: if (!cond) st_d = REQ_IDLE;   // release
        endcase
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) st_q <= REQ_IDLE;
        else            st_q <= st_d;
    end

    always_comb req_q = (st_q == REQ_HELD);

    AST_CAPTURE_NEEDS_COND: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $rose(req_q) |-> $past(cond)); // R1
endmodule

// File: rtl/lrm_sync_chain.sv
`timescale 1ns/1ps
module lrm_sync_chain #(
    parameter int unsigned DEPTH = 2
) (
    input  logic dst_clk,
    input  logic dst_rst_n,
    input  logic d,
    output logic first_q,
    output logic q
);
    logic [DEPTH-1:0] stg;

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) stg <= '0;
        else            stg <= {stg[DEPTH-2:0], d};
    end

    assign first_q = stg[0];
    assign q       = stg[DEPTH-1];
endmodule

// File: rtl/lrm_dst_merge.sv
`timescale 1ns/1ps
module lrm_dst_merge
    import lrm_pkg::*;
#(
    parameter int unsigned N_REQ = 4,
    parameter int unsigned DEPTH = 2
) (
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    input  logic [N_REQ-1:0] first_q,
    input  logic [N_REQ-1:0] sync_q,
    output logic             req_out
);
    localparam int unsigned CW = cnt_width(DEPTH);
    localparam logic [CW-1:0] LIM = CW'(DEPTH - 1);

    assign req_out = |sync_q;

    // checker counters: consecutive cycles of quiet / held first stages
    logic [CW-1:0] quiet_cnt;
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n)          quiet_cnt <= '0;
        else if (|first_q)       quiet_cnt <= '0;
        else if (quiet_cnt < LIM) quiet_cnt <= quiet_cnt + 1'b1;
    end

    AST_QUIET_OUTPUT_LOW: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (quiet_cnt >= LIM) |-> !req_out); // R6

    AST_OUT_LOW_AFTER_RESET: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        $rose(dst_rst_n) |-> !req_out); // R5

    for (genvar i = 0; i < N_REQ; i++) begin : g_held
        logic [CW-1:0] held_cnt;
        always_ff @(posedge dst_clk or negedge dst_rst_n) begin
            if (!dst_rst_n)           held_cnt <= '0;
            else if (!first_q[i])     held_cnt <= '0;
            else if (held_cnt < LIM)  held_cnt <= held_cnt + 1'b1;
        end
        AST_HELD_REQ_SEEN: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
            (held_cnt >= LIM) |-> req_out); // R7
    end
endmodule

// File: rtl/lvl_req_merger.sv
`timescale 1ns/1ps
module lvl_req_merger #(
    parameter int unsigned             N_REQ       = 4,
    parameter int unsigned             SYNC_DEPTH  = 2,
    parameter int unsigned             STATE_W     = 3,
    parameter logic [N_REQ-1:0]        DECODE_SEL  = '0,
    parameter logic [N_REQ*STATE_W-1:0] DECODE_CODE = '0
) (
    input  logic [N_REQ-1:0]         src_clk,
    input  logic [N_REQ-1:0]         src_rst_n,
    input  logic [N_REQ-1:0]         src_req,
    input  logic [N_REQ*STATE_W-1:0] src_state,
    input  logic                     dst_clk,
    input  logic                     dst_rst_n,
    output logic                     req_out
);
    logic [N_REQ-1:0] reg_req;
    logic [N_REQ-1:0] first_q;
    logic [N_REQ-1:0] sync_q;

    for (genvar i = 0; i < N_REQ; i++) begin : g_src
        lrm_src_stage #(
            .STATE_W   (STATE_W),
            .USE_DECODE(DECODE_SEL[i]),
            .MATCH_CODE(DECODE_CODE[i*STATE_W +: STATE_W])
        ) i_src (
            .src_clk  (src_clk[i]),
            .src_rst_n(src_rst_n[i]),
            .req_raw  (src_req[i]),
            .req_state(src_state[i*STATE_W +: STATE_W]),
            .req_q    (reg_req[i])
        );

        lrm_sync_chain #(.DEPTH(SYNC_DEPTH)) i_sync (
            .dst_clk  (dst_clk),
            .dst_rst_n(dst_rst_n),
            .d        (reg_req[i]),
            .first_q  (first_q[i]),
            .q        (sync_q[i])
        );
    end

    lrm_dst_merge #(.N_REQ(N_REQ), .DEPTH(SYNC_DEPTH)) i_merge (
        .dst_clk  (dst_clk),
        .dst_rst_n(dst_rst_n),
        .first_q  (first_q),
        .sync_q   (sync_q),
        .req_out  (req_out)
    );
endmodule

// File: tb/test_lvl_req_merger.sv
`timescale 1ns/1ps
module test_lvl_req_merger;
    localparam real CLK_PERIOD = 10.0;
    localparam int  N   = 3;
    localparam int  SW  = 3;
    localparam int  DEP = 2;
    localparam real WIN_NS = 2.0 * 23.0 + (DEP + 2) * CLK_PERIOD;
    localparam logic [SW-1:0] MATCH = 3'b101;

    logic [N-1:0]    src_clk = '0;
    logic [N-1:0]    src_rst_n = '0;
    logic [N-1:0]    src_req = '0;
    logic [N*SW-1:0] src_state = '0;
    logic            dst_clk = 1'b0;
    logic            dst_rst_n = 1'b0;
    logic            out2, out3;

    int errors = 0, checks = 0;

    always #(CLK_PERIOD/2.0) dst_clk = ~dst_clk;
    always #6.5  src_clk[0] = ~src_clk[0];
    always #8.5  src_clk[1] = ~src_clk[1];
    always #11.5 src_clk[2] = ~src_clk[2];

    lvl_req_merger #(.N_REQ(N), .SYNC_DEPTH(2), .STATE_W(SW), .DECODE_SEL(3'b100),
        .DECODE_CODE({MATCH, 3'b000, 3'b000})) i_lvl_req_merger (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_req(src_req), .src_state(src_state),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .req_out(out2));

    lvl_req_merger #(.N_REQ(N), .SYNC_DEPTH(3), .STATE_W(SW), .DECODE_SEL(3'b100),
        .DECODE_CODE({MATCH, 3'b000, 3'b000})) i_lvl_req_merger_d3 (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_req(src_req), .src_state(src_state),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .req_out(out3));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_dst(input int n);
        repeat (n) @(posedge dst_clk);
        @(negedge dst_clk);
    endtask

    // pattern: bits 0,1 raw; bit 2 via decode state. Raw bit 2 and junk states ignored (R2).
    task automatic apply(input logic [2:0] p);
        src_req   = {1'b1, p[1], p[0]};
        src_state = {(p[2] ? MATCH : 3'b000), 3'b101, 3'b101};
    endtask

    // model of whether any condition is true, for the phantom monitor (R6)
    logic model_any;
    assign model_any = src_req[0] | src_req[1] | (src_state[2*SW +: SW] == MATCH);
    realtime last_high = 0.0;
    int phantom = 0, d3_mis = 0;
    bit mon_on = 0;
    logic prev2 = 1'b0;
    always @(model_any) if (model_any) last_high = $realtime;
    always @(negedge dst_clk) begin
        if (model_any) last_high = $realtime;
        if (mon_on) begin
            if (out2 && ($realtime - last_high > WIN_NS)) phantom++;
            if (out3 !== prev2) d3_mis++;
        end
        prev2 = out2;
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        apply(3'b000);
        wait_dst(3);
        check(out2 == 1'b0 && out3 == 1'b0, "R5 out low in reset", int'(out2), 0);
        dst_rst_n = 1'b1; src_rst_n = '1;
        wait_dst(1);
        check(out2 == 1'b0, "R5 out low after reset", int'(out2), 0);
        mon_on = 1;

        // near-exhaustive sweep of request patterns (R2 R3 R4 R7 R9)
        for (int p = 0; p < 8; p++) begin
            apply(3'(p));
            wait_dst(8);
            check(out2 == (p != 0), "R4 R7 merged level d2", int'(out2), int'(p != 0));
            wait_dst(4);
            check(out3 == (p != 0), "R3 R9 merged level d3", int'(out3), int'(p != 0));
        end
        apply(3'b000); wait_dst(10);

        // overlapped handoff: no dip (R8)
        apply(3'b001); wait_dst(10);
        apply(3'b011); wait_dst(10);
        apply(3'b010);
        begin
            int lows = 0;
            for (int k = 0; k < 20; k++) begin wait_dst(0); if (!out2) lows++; @(posedge dst_clk); end
            check(lows == 0, "R8 handoff without dip", lows, 0);
        end
        apply(3'b000); wait_dst(10);

        // decode glitch through matching code between source edges (R1 R2)
        src_state[2*SW +: SW] = 3'b011; wait_dst(6);
        @(posedge src_clk[2]); #5;
        src_state[2*SW +: SW] = MATCH; #2;
        src_state[2*SW +: SW] = 3'b100;
        begin
            int highs = 0;
            for (int k = 0; k < 15; k++) begin wait_dst(0); if (out2 || out3) highs++; @(posedge dst_clk); end
            check(highs == 0, "R1 R2 transient decode ignored", highs, 0);
        end
        src_state = '0; wait_dst(4);

        // source reset holds requester idle (R5)
        src_req[0] = 1'b1; wait_dst(8);
        check(out2 == 1'b1, "R7 raw request seen", int'(out2), 1);
        src_rst_n[0] = 1'b0; wait_dst(8);
        check(out2 == 1'b0, "R5 source reset clears request", int'(out2), 0);
        src_rst_n[0] = 1'b1; wait_dst(8);
        check(out2 == 1'b1, "R5 request returns after release", int'(out2), 1);
        src_req[0] = 1'b0; wait_dst(10);
        check(out2 == 1'b0 && out3 == 1'b0, "R6 output low when idle", int'(out2), 0);

        check(phantom == 0, "R6 no phantom highs", phantom, 0);
        check(d3_mis == 0, "R9 depth3 lags depth2 by one cycle", d3_mis, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule